// File: doc/BRIEF.md
# JTAG TCK Shift Engine

This block is the host side of a JTAG probe. It makes the test clock TCK and, for one transfer, shifts a vector of TMS bits and a vector of TDI bits out towards the target while it collects the target's TDO bits. The low phase and the high phase of TCK are timed separately. Each phase length is a 12-bit value N that sets the phase to N+1 ticks. One tick is a fixed number of system clocks, set by the parameter `TICK_DIV`. With a 20 MHz tick, one tick is 50 ns, so each phase can be set anywhere from 50 ns up to 4096 ticks.

Outputs move only when TCK falls, or when a transfer begins with TCK already low. TDO is captured only in the clock where TCK rises. Making either phase longer therefore only adds time between an output change and the edge that samples it. A slow enough TCK meets the setup and hold needs of any compliant target.

The host writes the two phase lengths while the engine is idle. It then gives a bit count and the two vectors, and pulses `start`. `busy` stays high for the whole transfer. `done` pulses for one cycle with the captured vector on `tdo_vec`. The controller has three states:
- `ST_IDLE`: TCK low, waiting.
- `ST_LOW`: TCK low, counting the low phase.
- `ST_HIGH`: TCK high, counting the high phase.

It has four transitions:
- IDLE→LOW: an accepted start.
- LOW→HIGH: the low timer expires and TCK rises.
- HIGH→LOW: the high timer expires, more bits remain, and TCK falls with the next bit shown.
- HIGH→IDLE: the high timer expires on the last bit, TCK falls and `done` pulses.

Top module: `jtag_tck_shifter`

## Requirements
- R1: After reset, TCK, `busy` and `done` are low and `tdo_vec` is zero. Both phase lengths default to N=0, which is one tick.
- R2: Every TCK low phase inside a transfer lasts (N_low+1)·TICK_DIV system clocks. This includes the first low phase, counted from the cycle `busy` rises.
- R3: Every TCK high phase lasts (N_high+1)·TICK_DIV system clocks.
- R4: TMS and TDI change only in the cycle TCK falls, or in the cycle a transfer is accepted. The value present at the k-th TCK rise is bit k-1 of `tms_vec`/`tdi_vec`, so bits go out LSB first.
- R5: The TDO value in the cycle TCK rises for the k-th time is stored in bit k-1 of `tdo_vec`. Bits at and above the bit count read zero.
- R6: A transfer produces exactly `bit_count` TCK rising edges. A start with `bit_count` of 0 or above `MAX_BITS` is ignored, and `busy` stays low.
- R7: Writes to the phase lengths (`cfg_we`) are ignored while `busy` is high. They affect neither the running transfer nor later ones.
- R8: A start while idle raises `busy` on the next cycle, and a start while busy is ignored. `done` is a one-cycle pulse, issued in the same cycle that TCK returns low and `busy` clears.
- R9: TCK is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write both phase lengths (honoured only when idle) |
| cfg_low_len | input | PHASE_W | Low phase length N (N+1 ticks) |
| cfg_high_len | input | PHASE_W | High phase length N (N+1 ticks) |
| start | input | 1 | Begin a transfer |
| bit_count | input | CNT_W | Number of bits, 1 to MAX_BITS |
| tms_vec | input | MAX_BITS | TMS bits, LSB sent first |
| tdi_vec | input | MAX_BITS | TDI bits, LSB sent first |
| tdo_vec | output | MAX_BITS | Captured TDO bits, LSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench builds the engine with `TICK_DIV` = 2. This runs the tick prescaler, so a miscount inside a tick shows up as a wrong phase length in system clocks. `PHASE_W` stays at 12 and `MAX_BITS` at 32, so the bench can reach the full 4096-tick phase, a 32-bit transfer and the rejected counts 0 and 33. A bench model of the target shifts a TDO pattern on each TCK fall. This lets the capture order and the masking above the bit count be checked.

// File: rtl/jtag_shift_pkg.sv
package jtag_shift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } eng_state_t;

endpackage

// File: rtl/jsh_phase_timer.sv
module jsh_phase_timer #(
    parameter int PHASE_W  = 12,
    parameter int TICK_DIV = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] load_val,
    output logic               expire
);
    logic [PHASE_W-1:0] cnt_q;
    logic               tick;

    generate
        if (TICK_DIV == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PRE_W = $clog2(TICK_DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
            localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (load || pre_q == PRE_LAST)
                    pre_q <= '0;
                else
                    pre_q <= pre_q + PRE_ONE;
            end

            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    localparam logic [PHASE_W-1:0] CNT_ONE = PHASE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - CNT_ONE;
    end

    assign expire = tick && (cnt_q == '0);

endmodule

// File: rtl/jsh_out_shifter.sv
module jsh_out_shifter #(
    parameter int MAX_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    input  logic [MAX_BITS-1:0] tms_in,
    input  logic [MAX_BITS-1:0] tdi_in,
    output logic                tms_bit,
    output logic                tdi_bit
);
    logic [MAX_BITS-1:0] tms_sr_q;
    logic [MAX_BITS-1:0] tdi_sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms_sr_q <= '0;
            tdi_sr_q <= '0;
            tms_bit  <= 1'b0;
            tdi_bit  <= 1'b0;
        end else if (load) begin
            tms_bit  <= tms_in[0];
            tdi_bit  <= tdi_in[0];
            tms_sr_q <= tms_in >> 1;
            tdi_sr_q <= tdi_in >> 1;
        end else if (advance) begin
            tms_bit  <= tms_sr_q[0];
            tdi_bit  <= tdi_sr_q[0];
            tms_sr_q <= tms_sr_q >> 1;
            tdi_sr_q <= tdi_sr_q >> 1;
        end
    end

endmodule

// File: rtl/jsh_capture.sv
module jsh_capture #(
    parameter int MAX_BITS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic [IDX_W-1:0]    idx,
    input  logic                tdo_in,
    output logic [MAX_BITS-1:0] result
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result <= '0;
        else if (clear)
            result <= '0;
        else if (sample)
            result[idx] <= tdo_in;
    end

endmodule

// File: rtl/jtag_tck_shifter.sv
module jtag_tck_shifter
    import jtag_shift_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int PHASE_W  = 12,
    parameter int TICK_DIV = 1,
    localparam int CNT_W   = $clog2(MAX_BITS + 1),
    localparam int IDX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [PHASE_W-1:0]  cfg_low_len,
    input  logic [PHASE_W-1:0]  cfg_high_len,
    input  logic                start,
    input  logic [CNT_W-1:0]    bit_count,
    input  logic [MAX_BITS-1:0] tms_vec,
    input  logic [MAX_BITS-1:0] tdi_vec,
    output logic [MAX_BITS-1:0] tdo_vec,
    output logic                busy,
    output logic                done,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BITS);

    eng_state_t         state_q, state_d;
    logic [PHASE_W-1:0] low_len_q, high_len_q;
    logic [CNT_W-1:0]   count_q, idx_q;
    logic               tck_q, done_q;
    logic               expire, tmr_load;
    logic [PHASE_W-1:0] tmr_val;
    logic               go, last_bit;

    assign go       = (state_q == ST_IDLE) && start &&
                      (bit_count != '0) && (bit_count <= CNT_MAX);
    assign last_bit = (idx_q == count_q - CNT_ONE);

    // phase length registers, writable only when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len_q  <= '0;
            high_len_q <= '0;
        end else if (cfg_we && state_q == ST_IDLE) begin
            low_len_q  <= cfg_low_len;
            high_len_q <= cfg_high_len;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)     state_d = ST_LOW;
            ST_LOW:  if (expire) state_d = ST_HIGH;
            ST_HIGH: if (expire) state_d = last_bit ? ST_IDLE : ST_LOW;
            default:             state_d = ST_IDLE;
        endcase
    end

    // timer control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = low_len_q;
        unique case (state_q)
            ST_IDLE: tmr_load = go;
            ST_LOW: begin
                tmr_load = expire;
                tmr_val  = high_len_q;
            end
            ST_HIGH: tmr_load = expire && !last_bit;
            default: tmr_load = 1'b0;
        endcase
    end

    // registered outputs and bit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_q   <= 1'b0;
            done_q  <= 1'b0;
            count_q <= '0;
            idx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    tck_q <= 1'b0;
                    if (go) begin
                        count_q <= bit_count;
                        idx_q   <= '0;
                    end
                end
                ST_LOW: if (expire) tck_q <= 1'b1;
                ST_HIGH: if (expire) begin
                    tck_q <= 1'b0;
                    if (last_bit) done_q <= 1'b1;
                    else          idx_q  <= idx_q + CNT_ONE;
                end
                default: tck_q <= 1'b0;
            endcase
        end
    end

    jsh_phase_timer #(.PHASE_W(PHASE_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    jsh_out_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .advance ((state_q == ST_HIGH) && expire && !last_bit),
        .tms_in  (tms_vec),
        .tdi_in  (tdi_vec),
        .tms_bit (tms),
        .tdi_bit (tdi)
    );

    jsh_capture #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (go),
        .sample ((state_q == ST_LOW) && expire),
        .idx    (idx_q[IDX_W-1:0]),
        .tdo_in (tdo),
        .result (tdo_vec)
    );

    assign busy = (state_q != ST_IDLE);
    assign tck  = tck_q;
    assign done = done_q;

    // R9: no clock activity while idle
    assert_tck_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R4: outputs move only at a falling edge or at transfer acceptance
    assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tms) || !$stable(tdi)) |-> ($fell(tck) || $rose(busy)));

    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done coincides with TCK low and busy cleared
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tck && $fell(tck)));

    // R7: phase lengths frozen across a transfer
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(low_len_q) && $stable(high_len_q)));

endmodule

// File: tb/tb_jtag_tck_shifter.sv
module tb_jtag_tck_shifter;
    localparam int MAX_BITS = 32;
    localparam int PHASE_W  = 12;
    localparam int TICK_DIV = 2;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int NV       = 5;

    localparam int          V_CNT [NV] = '{8, 1, 32, 13, 5};
    localparam logic [31:0] V_TMS [NV] = '{32'h0000_00A5, 32'h1, 32'hDEAD_BEEF, 32'h0000_1F0F, 32'h1F};
    localparam logic [31:0] V_TDI [NV] = '{32'h0000_003C, 32'h0, 32'h1234_5678, 32'h0000_0AAA, 32'h0};
    localparam logic [31:0] V_PAT [NV] = '{32'h0000_0096, 32'h1, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h15};
    localparam int          V_LOW [NV] = '{0, 3, 1, 5, 0};
    localparam int          V_HIGH[NV] = '{0, 1, 4, 0, 7};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, start = 1'b0;
    logic [PHASE_W-1:0] cfg_low_len = '0, cfg_high_len = '0;
    logic [CNT_W-1:0] bit_count = '0;
    logic [MAX_BITS-1:0] tms_vec = '0, tdi_vec = '0, tdo_vec;
    logic busy, done, tck, tms, tdi, tdo;

    int tests = 0, fails = 0, cycles = 0;
    int rises = 0, falls = 0, rise_base = 0, fall_base = 0;
    int run_len = 0, low_err = 0, high_err = 0, exp_low = 2, exp_high = 2;
    int busy_seen = 0;
    logic prev_tck = 1'b0;
    logic [31:0] seen_tms = '0, seen_tdi = '0, tgt_pat = '0;
    logic [4:0] tidx;

    always #10 clk = ~clk;

    jtag_tck_shifter #(.MAX_BITS(MAX_BITS), .PHASE_W(PHASE_W), .TICK_DIV(TICK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_low_len(cfg_low_len),
        .cfg_high_len(cfg_high_len), .start(start), .bit_count(bit_count),
        .tms_vec(tms_vec), .tdi_vec(tdi_vec), .tdo_vec(tdo_vec), .busy(busy),
        .done(done), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

    // target model: shifts its pattern on each TCK fall
    assign tidx = 5'(falls - fall_base);
    assign tdo  = tgt_pat[tidx];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // phase-length and edge monitor
    always @(negedge clk) begin
        cycles++;
        if (busy) busy_seen++;
        if (tck !== prev_tck) begin
            if (tck) begin
                if (run_len != exp_low) low_err++;
                seen_tms[(rises - rise_base) % 32] = tms;
                seen_tdi[(rises - rise_base) % 32] = tdi;
                rises++;
                run_len = 1;
            end else begin
                if (run_len != exp_high) high_err++;
                falls++;
                run_len = busy ? 1 : 0;
            end
        end else if (busy || tck) begin
            run_len++;
        end else begin
            run_len = 0;
        end
        prev_tck = tck;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic write_cfg(input int l, input int h);
        @(negedge clk);
        cfg_we = 1'b1; cfg_low_len = PHASE_W'(l); cfg_high_len = PHASE_W'(h);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic begin_xfer(input int cnt, input logic [31:0] t_ms, input logic [31:0] t_di,
                              input logic [31:0] pat, input int l, input int h);
        @(negedge clk);
        exp_low = (l + 1) * TICK_DIV; exp_high = (h + 1) * TICK_DIV;
        low_err = 0; high_err = 0; rise_base = rises; fall_base = falls;
        seen_tms = '0; seen_tdi = '0; tgt_pat = pat;
        bit_count = CNT_W'(cnt); tms_vec = t_ms; tdi_vec = t_di; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    endtask

    task automatic end_xfer(input int cnt, input logic [31:0] t_ms, input logic [31:0] t_di,
                            input logic [31:0] pat);
        logic [31:0] mask;
        int guard;
        mask  = (cnt >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << cnt) - 1);
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk); guard++;
        end
        check(done && !busy && !tck, "R8 done with busy and tck low", {61'd0, done, busy, tck}, 64'h4);
        check(tdo_vec == (pat & mask), "R5 captured tdo", 64'(tdo_vec), 64'(pat & mask));
        check(rises - rise_base == cnt, "R6 rising edge count", 64'(rises - rise_base), 64'(cnt));
        check(seen_tms == (t_ms & mask) && seen_tdi == (t_di & mask), "R4 tms/tdi order",
              {seen_tms, seen_tdi}, {t_ms & mask, t_di & mask});
        check(low_err == 0, "R2 low phase length", 64'(low_err), 64'd0);
        check(high_err == 0, "R3 high phase length", 64'(high_err), 64'd0);
        @(negedge clk);
        check(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!tck && !busy && !done && tdo_vec == '0, "R1 reset outputs",
              {30'd0, tck, busy, done, tdo_vec}, 64'd0);
        rst_n = 1'b1;
        // R1 default phase lengths of one tick
        begin_xfer(2, 32'h2, 32'h1, 32'h3, 0, 0);
        end_xfer(2, 32'h2, 32'h1, 32'h3);

        // vector table
        for (int i = 0; i < NV; i++) begin
            write_cfg(V_LOW[i], V_HIGH[i]);
            begin_xfer(V_CNT[i], V_TMS[i], V_TDI[i], V_PAT[i], V_LOW[i], V_HIGH[i]);
            end_xfer(V_CNT[i], V_TMS[i], V_TDI[i], V_PAT[i]);
        end

        // R6 invalid counts 0 and 33 ignored
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            busy_seen = 0;
            bit_count = (c == 0) ? CNT_W'(0) : CNT_W'(33);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            check(busy_seen == 0 && !tck, "R6 invalid count ignored", 64'(busy_seen), 64'd0);
        end

        // R7 cfg write while busy ignored, R8 start while busy ignored
        write_cfg(2, 2);
        begin_xfer(4, 32'h9, 32'h6, 32'hA, 2, 2);
        repeat (3) @(negedge clk);
        cfg_we = 1'b1; cfg_low_len = 12'd9; cfg_high_len = 12'd9;
        @(negedge clk); cfg_we = 1'b0;
        bit_count = CNT_W'(20); start = 1'b1;
        @(negedge clk); start = 1'b0;
        end_xfer(4, 32'h9, 32'h6, 32'hA);
        begin_xfer(3, 32'h5, 32'h2, 32'h6, 2, 2);
        end_xfer(3, 32'h5, 32'h2, 32'h6);

        // R2/R3 longest phases
        write_cfg(4095, 4095);
        begin_xfer(1, 32'h1, 32'h1, 32'h0, 4095, 4095);
        end_xfer(1, 32'h1, 32'h1, 32'h0);

        // R9 idle tck stays low
        busy_seen = 0;
        repeat (10) @(negedge clk);
        check(!tck && busy_seen == 0, "R9 tck low while idle", 64'(tck), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule